// File: doc/BRIEF.md
# Three-Button Combination Lock Controller

This block is a clocked Moore state machine guarding a lock with three push buttons: a "go" button and two digit buttons, zero and one. The lock opens only when the go button is pressed and then the digits zero, one, one, zero follow in that order. Any wrong digit sends the machine to a fault state. Pressing a digit while the lock is open also sends it there. The fault state holds until go is pressed again.

Each button arrives as a synchronised pulse that lasts exactly one clock cycle per physical press. The single output, `unlock`, depends only on the present state. The next state and the output come from a 64-entry rule table. The table is addressed by the three state bits and the three button bits, and each entry holds three next-state bits and the unlock bit. The table contents are computed at elaboration rather than written out.

Top module: `comb_lock_fsm`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the machine enters the start state (code 000) and `unlock` is 0 in the following cycle.
- R2: A go press moves the machine to the start state with `unlock` 0 from any state. This holds even when digit buttons are pressed in the same cycle.
- R3: From the start state, the presses zero, one, one, zero (each without go) walk through states 001, 010, 011 and then to the open state 100. `unlock` is 1 exactly while the machine is in state 100, starting in the cycle after the fourth press.
- R4: In states 000, 001, 010 and 011, a single digit press that does not match the expected digit moves the machine to the fault state 101, and `unlock` stays 0.
- R5: A cycle with no button pressed leaves the state unchanged, so `unlock` holds its value.
- R6: In the open state, a press of zero or one without go moves the machine to the fault state, and `unlock` falls in the next cycle.
- R7: The fault state ignores digit presses. A later correct digit sequence without go never raises `unlock`.
- R8: Pressing zero and one in the same cycle without go is a wrong entry and leads to the fault state from any state.
- R9: The codes 110 and 111 are never entered. If they were reached, they drive `unlock` to 0 and go to fault on any cycle without go.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| press_go | input | 1 | One-cycle pulse from the go button |
| press_zero | input | 1 | One-cycle pulse from the zero digit button |
| press_one | input | 1 | One-cycle pulse from the one digit button |
| unlock | output | 1 | High while the lock is open |

## Verification
The bench starts from reset and applies every possible run of four cycles, each drawn from all eight go/zero/one combinations. These runs include idle cycles, simultaneous presses and go combined with digits. Every run is then followed by the correct code without go. That suffix tells the reached states apart by whether `unlock` rises and on which press it rises:
- a machine left in the start state opens on the fourth suffix press;
- a machine mid-code opens earlier or faults;
- a machine in fault never opens.

`unlock` is compared against an arithmetic model in every cycle.

// File: rtl/lock_pkg.sv
// Package: shared widths, state codes and the rule function for the lock.
// Assumes buttons are packed as {go, zero, one}, go in the top bit.
package lock_pkg;

    localparam int STATE_W = 3;
    localparam int BTN_W   = 3;
    localparam int ADDR_W  = STATE_W + BTN_W;
    localparam int ENTRY_W = STATE_W + 1;

    // Bit positions inside the packed button vector
    localparam int BTN_GO   = 2;
    localparam int BTN_ZERO = 1;
    localparam int BTN_ONE  = 0;

    // Fixed state codes
    localparam logic [STATE_W-1:0] ST_IDLE  = 3'b000;
    localparam logic [STATE_W-1:0] ST_D1    = 3'b001;
    localparam logic [STATE_W-1:0] ST_D2    = 3'b010;
    localparam logic [STATE_W-1:0] ST_D3    = 3'b011;
    localparam logic [STATE_W-1:0] ST_OPEN  = 3'b100;
    localparam logic [STATE_W-1:0] ST_FAULT = 3'b101;

    // Compute one rule-table entry {next_state, unlock} for an address {state, buttons}
    function automatic logic [ENTRY_W-1:0] rule_entry(input logic [ADDR_W-1:0] addr);
        logic [STATE_W-1:0] cur;
        logic [STATE_W-1:0] nxt;
        logic               go;
        logic               zero;
        logic               one;
        logic               legal;
        cur   = addr[ADDR_W-1 -: STATE_W];
        go    = addr[BTN_GO];
        zero  = addr[BTN_ZERO];
        one   = addr[BTN_ONE];
        legal = (cur <= ST_FAULT);
        if (go) begin
            nxt = ST_IDLE;
        end else if (!zero && !one) begin
            nxt = legal ? cur : ST_FAULT;
        end else if (zero && one) begin
            nxt = ST_FAULT;
        end else begin
            case (cur)
                ST_IDLE: nxt = zero ? ST_D1   : ST_FAULT;
                ST_D1:   nxt = one  ? ST_D2   : ST_FAULT;
                ST_D2:   nxt = one  ? ST_D3   : ST_FAULT;
                ST_D3:   nxt = zero ? ST_OPEN : ST_FAULT;
                default: nxt = ST_FAULT;
            endcase
        end
        return {nxt, (cur == ST_OPEN)};
    endfunction

endpackage

// File: rtl/lock_rule_rom.sv
// Module: lock_rule_rom
// Combinational rule table of 2**(SW+BW) entries, each {next_state, unlock}.
// Assumes the package rule function defines every entry; contents are built
// at elaboration by a generate loop, so no table is written out by hand.
module lock_rule_rom
    import lock_pkg::*;
#(
    parameter int SW = STATE_W,
    parameter int BW = BTN_W
) (
    input  logic [SW-1:0] state_i,
    input  logic [BW-1:0] btn_i,
    output logic [SW-1:0] next_o,
    output logic          open_o
);

    localparam int AW    = SW + BW;
    localparam int DEPTH = 1 << AW;
    localparam int EW    = SW + 1;

    logic [EW-1:0] tab [DEPTH];
    logic [EW-1:0] hit;

    // Fill each table word from the rule function
    for (genvar a = 0; a < DEPTH; a++) begin : g_entry
        assign tab[a] = rule_entry(AW'(a));
    end

    // Look up the entry for the present state and buttons
    always_comb begin
        hit    = tab[{state_i, btn_i}];
        next_o = hit[EW-1:1];
        open_o = hit[0];
    end

endmodule

// File: rtl/lock_state_reg.sv
// Module: lock_state_reg
// Holds the state code; synchronous active-low reset loads the idle code.
// Assumes next_i is valid every cycle.
module lock_state_reg
    import lock_pkg::*;
#(
    parameter int                SW       = STATE_W,
    parameter logic [SW-1:0]     RST_CODE = ST_IDLE
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-1:0] next_i,
    output logic [SW-1:0] state_o
);

    // Advance the state once per clock, or return to idle on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_o <= RST_CODE;
        end else begin
            state_o <= next_i;
        end
    end

endmodule

// File: rtl/comb_lock_fsm.sv
// Module: comb_lock_fsm
// Moore combination lock: go, then zero, one, one, zero opens it.
// Assumes each press input is a synchronised one-cycle pulse.
module comb_lock_fsm
    import lock_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic press_go,
    input  logic press_zero,
    input  logic press_one,
    output logic unlock
);

    logic [STATE_W-1:0] state_q;
    logic [STATE_W-1:0] state_d;
    logic [BTN_W-1:0]   btn;

    // Pack the buttons in table-address order
    always_comb begin
        btn           = '0;
        btn[BTN_GO]   = press_go;
        btn[BTN_ZERO] = press_zero;
        btn[BTN_ONE]  = press_one;
    end

    lock_rule_rom #(
        .SW(STATE_W),
        .BW(BTN_W)
    ) u_rom (
        .state_i(state_q),
        .btn_i  (btn),
        .next_o (state_d),
        .open_o (unlock)
    );

    lock_state_reg #(
        .SW      (STATE_W),
        .RST_CODE(ST_IDLE)
    ) u_state (
        .clk    (clk),
        .rst_n  (rst_n),
        .next_i (state_d),
        .state_o(state_q)
    );

endmodule

// File: rtl/lock_fsm_checker.sv
// Module: lock_fsm_checker
// Property checks for comb_lock_fsm, attached by bind below.
module lock_fsm_checker
    import lock_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               press_go,
    input logic               press_zero,
    input logic               press_one,
    input logic               unlock,
    input logic [STATE_W-1:0] state
);

    AST_RESET_CLOSED: assert property (@(posedge clk)
        !rst_n |=> (state == ST_IDLE && !unlock)); // R1

    AST_GO_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        press_go |=> (state == ST_IDLE && !unlock)); // R2

    AST_OPEN_ONLY_FROM_D3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlock) |-> $past(state == ST_D3 && press_zero && !press_one && !press_go)); // R3

    AST_UNLOCK_MATCHES_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        unlock == (state == ST_OPEN)); // R3

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!press_go && !press_zero && !press_one) |=> $stable(state)); // R5

    AST_OPEN_DIGIT_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OPEN && !press_go && (press_zero || press_one)) |=> (state == ST_FAULT)); // R6

    AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FAULT && !press_go) |=> (state == ST_FAULT)); // R7

    AST_BOTH_DIGITS_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (!press_go && press_zero && press_one) |=> (state == ST_FAULT)); // R8

    AST_NO_SPARE_CODES: assert property (@(posedge clk) disable iff (!rst_n)
        state <= ST_FAULT); // R9

endmodule

bind comb_lock_fsm lock_fsm_checker u_lock_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .press_go  (press_go),
    .press_zero(press_zero),
    .press_one (press_one),
    .unlock    (unlock),
    .state     (state_q)
);

// File: tb/test_comb_lock_fsm.sv
// Bench: every four-cycle button run from reset, then the code without go.
module test_comb_lock_fsm;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic press_go = 1'b0;
    logic press_zero = 1'b0;
    logic press_one = 1'b0;
    logic unlock;

    int checks = 0;
    int errors = 0;
    int mdl_st = 0;   // 0 idle,1..3 digits,4 open,5 fault

    always #5 clk = ~clk;

    comb_lock_fsm i_comb_lock_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .press_go  (press_go),
        .press_zero(press_zero),
        .press_one (press_one),
        .unlock    (unlock)
    );

    // Reference next state; b is {go, zero, one}
    function automatic int mdl_next(input int s, input logic [2:0] b);
        int want;
        if (b[2]) return 0;
        if (b == 3'b000) return s;
        if (b == 3'b011) return 5;
        if (s == 4 || s == 5) return 5;
        want = (s == 0 || s == 3) ? 3'b010 : 3'b001;
        return (b == want[2:0]) ? s + 1 : 5;
    endfunction

    function automatic string tag_of(input int s, input logic [2:0] b);
        if (b[2]) return "R2";
        if (b == 3'b000) return "R5";
        if (b == 3'b011) return "R8";
        if (s == 4) return "R6";
        if (s == 5) return "R7";
        if (mdl_next(s, b) == 5) return "R4";
        return "R3";
    endfunction

    task automatic compare(input string req, input logic exp);
        checks++;
        if (unlock !== exp) begin
            errors++;
            $display("FAIL %s: unlock=%b expected=%b", req, unlock, exp);
        end
    endtask

    // Drive one cycle of buttons at a falling edge, check at the next one
    task automatic step(input logic [2:0] b);
        string req;
        req = tag_of(mdl_st, b);
        {press_go, press_zero, press_one} = b;
        @(negedge clk);
        mdl_st = mdl_next(mdl_st, b);
        compare(req, mdl_st == 4);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        {press_go, press_zero, press_one} = 3'b000;
        @(negedge clk);
        mdl_st = 0;
        compare("R1", 1'b0);
        rst_n = 1'b1;
    endtask

    initial begin
        #2_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        for (int p = 0; p < 4096; p++) begin
            do_reset();
            for (int k = 0; k < 4; k++) begin
                step(3'((p >> (3 * k)) & 7));
            end
            // Correct code without go: separates idle, digit and fault states
            step(3'b010);
            step(3'b001);
            step(3'b001);
            step(3'b010);
        end
        // R7: fault survives an idle cycle and a full code; R5 hold while open
        do_reset();
        step(3'b011);
        step(3'b000);
        step(3'b010); step(3'b001); step(3'b001); step(3'b010);
        step(3'b100);
        step(3'b010); step(3'b001); step(3'b001); step(3'b010);
        step(3'b000); step(3'b000);
        step(3'b001);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule